// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR SRAM

This block is a synthesizable, scaled-down model of a quad-data-rate static memory. It has a write data input and a read data output that are fully separate, so a read burst and a write burst can move at the same time. Both ports share one address bus. A read command and its address are captured on the edge that stands for the rising edge of K. A write command and its address are captured on the edge that stands for the rising edge of K#. Every address holds four words. They move in or out one word per half-cycle, so one burst takes two K cycles.

Double data rate is modelled with a clock at twice the K rate, `clk2x`. An input flag `k_phase` tells each `clk2x` edge what it stands for: 0 for the K-rising edge, 1 for the K#-rising edge. Read latency comes in two modes: a long one of one and a half K cycles and a short one of one K cycle. Reads are coherent with writes still in flight. Words of a burst that have arrived but are not yet committed to the array are forwarded, merged byte by byte, ahead of the array contents. An echo strobe pair follows the half-cycle timing so a receiver can capture the read data.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_n` is low at a `clk2x` edge, the outputs take these values after that edge: `rd_valid`=0, `rd_data`=0, `prot_err`=0, `echo_p`=0 and `echo_n`=1.
- R2: A read command is captured only on an edge with `k_phase`=0 and `rd_sel_n`=0. A write command is captured only on an edge with `k_phase`=1 and `wr_sel_n`=0. A select that is low on the other phase has no effect and does not raise `prot_err`.
- R3: A write command captured on edge E takes its data on edges E+1, E+2, E+3 and E+4, one beat per edge. The beat taken on edge E+1+k is stored as word k (k = 0..3) of the address captured with the command.
- R4: During a write beat, byte-select bit `wr_be[l]` = 1 writes lane l, which is bits [l*LANE_W +: LANE_W] of `wr_data`, with LANE_W = WIDTH/LANES. A lane whose select is 0 keeps its old contents.
- R5: With `lat_long`=1, a read captured on edge T shows word 0 on `rd_data` after edge T+3, and words 1, 2 and 3 after edges T+4, T+5 and T+6.
- R6: With `lat_long`=0, a read captured on edge T shows word 0 after edge T+2, and words 1 to 3 after each of the next three edges.
- R7: `rd_valid` is 1 for exactly the four half-cycles that carry the words of one accepted read. At every other time `rd_valid` is 0 and `rd_data` is 0.
- R8: The word presented after edge X reflects every write beat taken on any edge before X, including the beats of a burst whose later beats have not yet arrived. A beat taken on edge X itself is not included.
- R9: After a command is accepted on a port, that port ignores its select on its own phase for the next three edges. A select that is ignored this way sets `prot_err`, which then stays 1 until reset.
- R10: Commands spaced exactly four edges apart are all accepted. Reads spaced this way give an unbroken run of `rd_valid`.
- R11: After each edge with `rst_n` high, `echo_p` equals 1 if that edge had `k_phase`=0 and 0 otherwise, and `echo_n` is always the complement of `echo_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the K rate; every rising edge is one half-cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| k_phase | input | 1 | 0 on edges standing for K rising, 1 on edges standing for K# rising |
| lat_long | input | 1 | 1: read latency of three edges; 0: read latency of two edges |
| rd_sel_n | input | 1 | Active-low read select, sampled when k_phase is 0 |
| wr_sel_n | input | 1 | Active-low write select, sampled when k_phase is 1 |
| addr | input | AW | Shared address bus, AW = clog2(DEPTH) |
| wr_data | input | WIDTH | Write beat data |
| wr_be | input | LANES | Per-lane write enables for the current beat |
| rd_data | output | WIDTH | Read beat data, zero when idle |
| rd_valid | output | 1 | High while rd_data carries a burst word |
| echo_p | output | 1 | Echo strobe, high after K-rising edges |
| echo_n | output | 1 | Complement of echo_p |
| prot_err | output | 1 | Sticky flag for a command issued while its port was busy |

## Verification
The assertions take for granted that `k_phase` flips on every edge outside reset and that `lat_long` changes only while `rst_n` is low. The bench drives `k_phase` from a counter that toggles on every edge, even during reset, and it changes the latency mode only right before it asserts reset. Addresses in the random part are limited to locations that were filled first, so no read returns an uninitialized word. Selects are driven on both phases and during busy windows, so the ignore rules and the error flag are exercised as well.

// File: rtl/qsr_pkg.sv
// Package: shared constants and types for the burst-of-four DDR SRAM model.
// Assumes a fixed burst length of four words per address.
package qsr_pkg;
    localparam int BURST  = 4;
    localparam int BEAT_W = $clog2(BURST);
    localparam int HOLD_N = BURST - 1;
    typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qsr_cmd_port.sv
// Command capture for one port. A command is taken when the select is low on
// the port's own phase and the port is idle. After that the port stays busy
// for BURST-1 further edges. A select seen while busy is dropped and sets a
// sticky error. Assumes phase alternates on every edge.
module qsr_cmd_port
    import qsr_pkg::*;
#(
    parameter logic ACC_PHASE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase,
    input  logic sel_n,
    output logic accept,
    output logic err
);
    beat_t busy_cnt;
    logic  busy;
    logic  own_slot;

    assign busy     = (busy_cnt != '0);
    assign own_slot = !sel_n && (phase == ACC_PHASE);

    // Accept a command on an idle own-phase slot.
    always_comb accept = own_slot && !busy;

    // Count down the busy window and latch protocol errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            err      <= 1'b0;
        end else begin
            if (accept)
                busy_cnt <= beat_t'(BURST - 1);
            else if (busy)
                busy_cnt <= busy_cnt - 1'b1;
            if (own_slot && busy)
                err <= 1'b1;
        end
    end

    assert_cmd_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept ##1 !accept ##1 !accept);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/qsr_store.sv
// Storage for the array plus write-burst collection. Write beats 0..BURST-2
// wait in holding registers. On the last beat the whole burst is committed,
// and the last beat goes straight to the array. Reads merge held bytes over
// the array word, so every beat taken on an earlier edge is visible.
// Assumes wr_start only when the previous burst is done or on its last beat.
module qsr_store
    import qsr_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int WIDTH = 18,
    parameter int LANES = 2,
    localparam int AW     = $clog2(DEPTH),
    localparam int LANE_W = WIDTH / LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [LANES-1:0] wr_be,
    input  logic [AW-1:0]    rd_addr,
    input  beat_t            rd_beat,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] bank [BURST][DEPTH];
    logic             run;
    beat_t            idx;
    logic [AW-1:0]    waddr;
    logic [WIDTH-1:0] hold_d  [HOLD_N];
    logic [LANES-1:0] hold_be [HOLD_N];
    logic [HOLD_N-1:0] hold_v;
    logic             last;

    assign last = rst_n && run && (idx == beat_t'(BURST - 1));

    // Burst sequencing: track the beat index and which holding words are filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            idx    <= '0;
            waddr  <= '0;
            hold_v <= '0;
        end else begin
            if (run) begin
                if (last) begin
                    hold_v <= '0;
                    run    <= 1'b0;
                end else begin
                    hold_v[idx] <= 1'b1;
                    idx         <= idx + 1'b1;
                end
            end
            if (wr_start) begin
                run   <= 1'b1;
                idx   <= '0;
                waddr <= wr_addr;
            end
        end
    end

    // Capture early beats of a burst into the holding registers.
    always_ff @(posedge clk) begin
        if (rst_n && run && !last) begin
            for (int h = 0; h < HOLD_N; h++) begin
                if (beat_t'(h) == idx) begin
                    hold_d[h]  <= wr_data;
                    hold_be[h] <= wr_be;
                end
            end
        end
    end

    // Commit held words and the final beat into the array, lane by lane.
    always_ff @(posedge clk) begin
        if (last) begin
            for (int b = 0; b < HOLD_N; b++)
                for (int l = 0; l < LANES; l++)
                    if (hold_v[b] && hold_be[b][l])
                        bank[b][waddr][l*LANE_W +: LANE_W] <= hold_d[b][l*LANE_W +: LANE_W];
            for (int l = 0; l < LANES; l++)
                if (wr_be[l])
                    bank[BURST-1][waddr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
        end
    end

    // Read word: array contents with pending held bytes forwarded on top.
    always_comb begin
        rd_word = bank[rd_beat][rd_addr];
        if (run && (waddr == rd_addr)) begin
            for (int h = 0; h < HOLD_N; h++) begin
                if ((beat_t'(h) == rd_beat) && hold_v[h]) begin
                    for (int l = 0; l < LANES; l++)
                        if (hold_be[h][l])
                            rd_word[l*LANE_W +: LANE_W] = hold_d[h][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assert_commit_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (hold_v == '0));
    assert_no_start_midburst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |-> !wr_start);
endmodule

// File: rtl/qsr_read_path.sv
// Read pipeline: delays an accepted read by the selected latency, then
// presents the four burst words on consecutive edges and drives zero when
// idle. It also drives the echo strobe pair from the phase flag.
// Assumes lat_long is static outside reset.
module qsr_read_path
    import qsr_pkg::*;
#(
    parameter int AW    = 8,
    parameter int WIDTH = 18,
    localparam int DLY  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic             lat_long,
    input  logic             req,
    input  logic [AW-1:0]    req_addr,
    output logic [AW-1:0]    fetch_addr,
    output beat_t            fetch_beat,
    input  logic [WIDTH-1:0] fetch_word,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             echo_p,
    output logic             echo_n
);
    logic [DLY-1:0] dv;
    logic [AW-1:0]  da [DLY];
    logic           launch;
    logic [AW-1:0]  launch_addr;
    logic           out_run;
    beat_t          out_idx;
    logic [AW-1:0]  out_addr;

    assign launch      = lat_long ? dv[DLY-1] : dv[DLY-2];
    assign launch_addr = lat_long ? da[DLY-1] : da[DLY-2];
    assign fetch_addr  = launch ? launch_addr : out_addr;
    assign fetch_beat  = launch ? '0 : out_idx;

    // Latency delay line for accepted read requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv <= '0;
            for (int i = 0; i < DLY; i++) da[i] <= '0;
        end else begin
            dv    <= {dv[DLY-2:0], req};
            da[0] <= req_addr;
            for (int i = 1; i < DLY; i++) da[i] <= da[i-1];
        end
    end

    // Burst output sequencer: one word per edge, zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_run  <= 1'b0;
            out_idx  <= '0;
            out_addr <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (launch) begin
            out_run  <= 1'b1;
            out_idx  <= beat_t'(1);
            out_addr <= launch_addr;
            rd_valid <= 1'b1;
            rd_data  <= fetch_word;
        end else if (out_run) begin
            out_idx  <= out_idx + 1'b1;
            rd_valid <= 1'b1;
            rd_data  <= fetch_word;
            if (out_idx == beat_t'(BURST - 1))
                out_run <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end
    end

    // Echo strobe pair tracks which kind of edge launched the current half-cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_p <= 1'b0;
            echo_n <= 1'b1;
        end else begin
            echo_p <= !phase;
            echo_n <= phase;
        end
    end

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));
    assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);
    assert_long_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_long && dv[DLY-1]) |=> rd_valid);
    assert_short_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_long && dv[DLY-2]) |=> rd_valid);
    assert_echo_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        echo_p != echo_n);
    assert_echo_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (echo_p == !$past(phase)));
endmodule

// File: rtl/qdr_burst_sram.sv
// Top: burst-of-four dual-port DDR SRAM model. Read and write commands share
// one address bus on alternate half-cycles. Each port has its own command
// capture, and reads are coherent with writes still in flight.
// Assumes k_phase alternates every edge and lat_long changes only in reset.
module qdr_burst_sram
    import qsr_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int WIDTH = 18,
    parameter int LANES = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             k_phase,
    input  logic             lat_long,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [LANES-1:0] wr_be,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             echo_p,
    output logic             echo_n,
    output logic             prot_err
);
    logic             rd_acc, wr_acc, rd_err, wr_err;
    logic [AW-1:0]    f_addr;
    beat_t            f_beat;
    logic [WIDTH-1:0] f_word;

    qsr_cmd_port #(.ACC_PHASE(1'b0)) u_rd_cmd (
        .clk(clk2x), .rst_n(rst_n), .phase(k_phase), .sel_n(rd_sel_n),
        .accept(rd_acc), .err(rd_err));

    qsr_cmd_port #(.ACC_PHASE(1'b1)) u_wr_cmd (
        .clk(clk2x), .rst_n(rst_n), .phase(k_phase), .sel_n(wr_sel_n),
        .accept(wr_acc), .err(wr_err));

    qsr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LANES(LANES)) u_store (
        .clk(clk2x), .rst_n(rst_n), .wr_start(wr_acc), .wr_addr(addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_addr(f_addr), .rd_beat(f_beat),
        .rd_word(f_word));

    qsr_read_path #(.AW(AW), .WIDTH(WIDTH)) u_rd_path (
        .clk(clk2x), .rst_n(rst_n), .phase(k_phase), .lat_long(lat_long),
        .req(rd_acc), .req_addr(addr), .fetch_addr(f_addr), .fetch_beat(f_beat),
        .fetch_word(f_word), .rd_valid(rd_valid), .rd_data(rd_data),
        .echo_p(echo_p), .echo_n(echo_n));

    // Either port's sticky error raises the block flag.
    assign prot_err = rd_err | wr_err;

    assert_phase_toggles_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
        1'b1 |=> (k_phase != $past(k_phase)));
    assert_mode_static_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
        1'b1 |=> $stable(lat_long));
endmodule

// File: tb/sim_qdr_burst_sram.sv
// Bench: drives one edge at a time, predicts every output from a word-level
// memory model and compares on the falling edge.
module sim_qdr_burst_sram;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 256;
    localparam int W      = 18;
    localparam int LN     = 2;
    localparam int LW     = W / LN;
    localparam int AW     = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n, k_phase, lat_long, rd_sel_n, wr_sel_n;
    logic [AW-1:0] addr;
    logic [W-1:0]  wr_data, rd_data;
    logic [LN-1:0] wr_be;
    logic          rd_valid, echo_p, echo_n, prot_err;

    always #(PERIOD/2) clk = ~clk;

    qdr_burst_sram #(.DEPTH(DEPTH), .WIDTH(W), .LANES(LN)) u0 (
        .clk2x(clk), .rst_n(rst_n), .k_phase(k_phase), .lat_long(lat_long),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_data(rd_data), .rd_valid(rd_valid), .echo_p(echo_p),
        .echo_n(echo_n), .prot_err(prot_err));

    int    n_vec = 0, n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [W-1:0]  ref_mem [DEPTH][4];
    bit            ev [16];
    logic [AW-1:0] ea [16];
    int            ei [16];
    int            xe = 0, lat = 3;
    bit            ph = 0;
    int            m_rbusy = 0, m_wbusy = 0, m_wbeats = 0;
    logic [AW-1:0] m_waddr = '0;
    bit            m_err = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h edge=%0d", req, what, act, exp, xe);
        end
    endtask

    // One half-cycle: drive, predict, clock, compare.
    task automatic step(bit rs, bit ws, logic [AW-1:0] a, logic [W-1:0] d, logic [LN-1:0] be);
        int s;
        bit xv;
        logic [W-1:0] xd;
        k_phase = ph; rd_sel_n = rs; wr_sel_n = ws; addr = a; wr_data = d; wr_be = be;
        s  = xe % 16;
        xv = ev[s];
        xd = xv ? ref_mem[ea[s]][ei[s]] : '0;   // R8: only beats before this edge
        ev[s] = 0;
        if (m_wbeats > 0) begin                 // R3/R4 beat into word 4-m_wbeats
            int b;
            b = 4 - m_wbeats;
            for (int l = 0; l < LN; l++)
                if (be[l]) ref_mem[m_waddr][b][l*LW +: LW] = d[l*LW +: LW];
            m_wbeats--;
        end
        if (!ph && !rs) begin
            if (m_rbusy > 0) m_err = 1;
            else begin
                for (int i = 0; i < 4; i++) begin
                    int t;
                    t = (xe + lat + i) % 16;
                    ev[t] = 1; ea[t] = a; ei[t] = i;
                end
                m_rbusy = 4;
            end
        end
        if (ph && !ws) begin
            if (m_wbusy > 0) m_err = 1;
            else begin m_wbeats = 4; m_waddr = a; m_wbusy = 4; end
        end
        if (m_rbusy > 0) m_rbusy--;
        if (m_wbusy > 0) m_wbusy--;
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        chk(cur_req, "rd_valid (R7)", 32'(rd_valid), 32'(xv));
        chk(cur_req, "rd_data", 32'(rd_data), 32'(xd));
        chk("R11", "echo_p", 32'(echo_p), 32'(!ph));
        chk("R11", "echo_n", 32'(echo_n), 32'(ph));
        chk("R9", "prot_err", 32'(prot_err), 32'(m_err));
        xe++;
        ph = !ph;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1, 1, '0, '0, '0);
    endtask

    task automatic align(bit want);
        if (ph != want) idle(1);
    endtask

    task automatic do_reset(bit long_mode);
        lat_long = long_mode;
        rst_n = 0;
        for (int i = 0; i < 4; i++) begin
            k_phase = ph; rd_sel_n = 1; wr_sel_n = 1; addr = '0; wr_data = '0; wr_be = '0;
            @(posedge clk); @(negedge clk);
            ph = !ph;
        end
        n_vec++;
        chk("R1", "rd_valid", 32'(rd_valid), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
        chk("R1", "prot_err", 32'(prot_err), 0);
        chk("R1", "echo_p", 32'(echo_p), 0);
        chk("R1", "echo_n", 32'(echo_n), 1);
        for (int i = 0; i < 16; i++) ev[i] = 0;
        m_rbusy = 0; m_wbusy = 0; m_wbeats = 0; m_err = 0;
        lat = long_mode ? 3 : 2;
        rst_n = 1;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; lat_long = 1;
        for (int mode = 1; mode >= 0; mode--) begin
            do_reset(bit'(mode));
            // R3 / R10: back-to-back full writes fill addresses 0..15
            cur_req = "R3";
            align(1);
            for (int a = 0; a <= 16; a++)
                for (int k = 0; k < 4; k++)
                    step(1, !(k == 0 && a < 16), AW'(a), W'($urandom), '1);
            idle(4);
            // R5 / R6 / R10: back-to-back reads give an unbroken valid run
            cur_req = (mode == 1) ? "R5" : "R6";
            align(0);
            for (int a = 0; a < 16; a++)
                for (int k = 0; k < 4; k++)
                    step(!(k == 0), 1, AW'(a), '0, '0);
            idle(8);
            // R4: per-lane masking
            cur_req = "R4";
            align(1);
            step(1, 0, 3, '0, '0);
            step(1, 1, 0, W'($urandom), 2'b01);
            step(1, 1, 0, W'($urandom), 2'b10);
            step(1, 1, 0, W'($urandom), 2'b00);
            step(1, 1, 0, W'($urandom), 2'b11);
            align(0);
            step(0, 1, 3, '0, '0);
            idle(8);
            // R8: read issued while the write burst to the same address arrives
            cur_req = "R8";
            align(1);
            step(1, 0, 5, '0, '0);
            step(0, 1, 5, W'($urandom), 2'b01);
            step(1, 1, 0, W'($urandom), 2'b11);
            step(1, 1, 0, W'($urandom), 2'b10);
            step(1, 1, 0, W'($urandom), 2'b11);
            idle(8);
            align(0);
            step(0, 0, 6, '0, '0);
            step(1, 0, 6, '0, '0);
            for (int k = 0; k < 4; k++) step(1, 1, 0, W'($urandom), LN'($urandom));
            idle(8);
            // R2: selects on the wrong phase are ignored without error
            cur_req = "R2";
            align(0);
            step(1, 0, 7, W'($urandom), '1);
            step(0, 1, 7, W'($urandom), '1);
            idle(6);
            n_vec++;
            chk("R2", "prot_err after wrong-phase selects", 32'(prot_err), 0);
            // R9: read select inside busy window is dropped and flagged
            cur_req = "R9";
            align(0);
            step(0, 1, 1, '0, '0);
            step(1, 1, 0, '0, '0);
            step(0, 1, 2, '0, '0);
            idle(8);
            n_vec++;
            chk("R9", "prot_err after busy select", 32'(prot_err), 1);
            // R8: random mixed traffic on filled addresses
            cur_req = "R8";
            for (int i = 0; i < 500; i++)
                step(bit'($urandom % 2), bit'($urandom % 2), AW'($urandom % 16),
                     W'($urandom), LN'($urandom));
            idle(10);
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule